// File: doc/BRIEF.md
# Two-Pattern Transition Test Sequencer

This block drives a single chain of multiplexed scan flip-flops through the steps of a transition-fault test. For every pattern it loads an initialization vector, launches a second vector at speed, captures the circuit's answer one fast cycle later, and then shifts that answer out. A mode bit given with each start command picks how the second vector is made. In the shifted-launch variant the chain moves one more place and takes a fresh launch bit. In the response-launch variant scan enable is already low at the launch edge, so the chain's own functional response becomes the launch vector.

The sequencer reads bits from a serial pattern source, one bit for each cycle in which it asserts a consume strobe. It drives the chain's scan enable and scan input, and it drives a clock-speed select: low picks the slow shift clock and high picks the at-speed clock. It also drives a clock enable that stops the chain completely while no sequence runs. The unload of each response doubles as the load of the next initialization vector. A later start therefore goes straight to the launch step. When the unload is complete, a one-cycle done strobe appears together with the full response word.

Top module: `dlytest_seq`

## Requirements
- R1: After reset the block is idle: scan enable, speed select, chain clock enable, consume strobe and done are all 0, and the response word is 0.
- R2: A start accepted while idle with no vector preloaded begins with exactly CHAIN_LEN load cycles. Each has scan enable 1, speed select 0 (slow), consume strobe 1, and scan input equal to the source bit.
- R3: With mode 1 (shifted launch), one extra cycle follows the last load shift. It has scan enable 1, speed select 1 and consume strobe 1 (the launch bit). Then comes one capture cycle with scan enable 0 and speed select 1.
- R4: With mode 0 (response launch), scan enable is 0 from the cycle after the last load shift. Two at-speed cycles follow (launch, then capture), neither of which consumes a source bit.
- R5: Every cycle in which the chain shifts by loading or unloading uses the slow select. Only the launch and capture cycles use the fast select.
- R6: After capture come exactly CHAIN_LEN unload cycles, with scan enable 1, slow select and consume strobe 1. Each feeds the next source bit into the chain.
- R7: Done is 1 for exactly one cycle, the cycle after the last unload shift. The response word then has bit i equal to chain stage i at capture, where stage 0 is next to the scan input and stage CHAIN_LEN-1 drives scan out and leaves first. At all other times the response word holds its value, changing only during unload.
- R8: A start accepted after a completed unload skips loading, because the chain already holds the vector shifted in during that unload. The launch cycle of the chosen mode comes immediately.
- R9: A start that arrives while a sequence is running is ignored. The mode input is sampled only when a start is accepted.
- R10: The chain clock enable is 1 in every cycle of a running sequence and 0 while idle, so the chain holds its contents between patterns.
- R11: The scan input is 0 in every cycle that does not consume a source bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start command, accepted only while idle |
| mode_i | input | 1 | Launch mode for this pattern: 1 shifted launch, 0 response launch |
| pat_bit_i | input | 1 | Current bit from the serial pattern source |
| pat_take_o | output | 1 | Consume strobe: the source advances after this cycle |
| scan_en_o | output | 1 | Scan enable to the chain |
| scan_in_o | output | 1 | Serial data into chain stage 0 |
| scan_out_i | input | 1 | Serial data from chain stage CHAIN_LEN-1 |
| fast_clk_o | output | 1 | Clock-speed select: 1 at-speed, 0 slow shift |
| tclk_en_o | output | 1 | Chain clock enable |
| done_o | output | 1 | One-cycle end-of-unload strobe |
| resp_o | output | CHAIN_LEN | Unloaded response word |

## Verification
The bench builds the sequencer with CHAIN_LEN set to 6. This keeps one full pattern under twenty cycles, so a single short run covers the first load from reset, both launch modes, the skip-load path after a preloaded unload, and starts poked in the middle of a load and of an unload. An even chain length that is not a power of two checks that the shift counter wraps at the chain length and not at its natural binary limit. A bench-side chain with a nonlinear next-state function makes the two launch modes give different captures from the same vector, so a wrong scan-enable level at launch shows up in the response word.

// File: rtl/dlytest_pkg.sv
package dlytest_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE      = 3'd0,
    SQ_LOAD      = 3'd1,
    SQ_LAUNCH_SH = 3'd2,
    SQ_LAUNCH_FN = 3'd3,
    SQ_CAPTURE   = 3'd4,
    SQ_UNLOAD    = 3'd5
  } sq_state_e;

  typedef struct packed {
    logic tclk_en;
    logic se;
    logic fast;
    logic take;
  } sq_ctrl_t;

  localparam sq_ctrl_t SQ_CTRL_OFF = '{tclk_en: 1'b0, se: 1'b0, fast: 1'b0, take: 1'b0};

endpackage

// File: rtl/dlytest_rst_sync.sv
module dlytest_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/dlytest_bit_counter.sv
module dlytest_bit_counter #(
  parameter int CHAIN_LEN = 8,
  localparam int CNT_W = (CHAIN_LEN > 2) ? $clog2(CHAIN_LEN) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign last_o = (cnt_q == CNT_W'(CHAIN_LEN - 1));
  assign cnt_en = clr_i | inc_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (inc_i) begin
      cnt_d = last_o ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/dlytest_resp_unload.sv
module dlytest_resp_unload #(
  parameter int CHAIN_LEN = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_i,
  input  logic                 last_i,
  input  logic                 scan_out_i,
  output logic [CHAIN_LEN-1:0] resp_o,
  output logic                 done_o
);

  logic [CHAIN_LEN-1:0] resp_q;
  logic [CHAIN_LEN-1:0] resp_d;
  logic                 done_q;
  logic                 done_d;

  always_comb begin
    resp_d = {resp_q[CHAIN_LEN-2:0], scan_out_i};
    done_d = shift_i & last_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_q <= '0;
    end else if (shift_i) begin
      resp_q <= resp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  assign resp_o = resp_q;
  assign done_o = done_q;

endmodule

// File: rtl/dlytest_seq_fsm.sv
module dlytest_seq_fsm
  import dlytest_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_i,
  input  logic     mode_i,
  input  logic     last_i,
  output sq_ctrl_t ctrl_o,
  output logic     cnt_clr_o,
  output logic     cnt_inc_o,
  output logic     unload_o
);

  sq_state_e state_q, state_d;
  logic      mode_q, mode_d;
  logic      primed_q, primed_d;
  logic      launch_pick;

  // Launch state for a given mode bit: 1 shifts, 0 clocks functionally.
  always_comb begin
    launch_pick = (state_q == SQ_IDLE) ? mode_i : mode_q;
  end

  always_comb begin
    state_d  = state_q;
    mode_d   = mode_q;
    primed_d = primed_q;
    unique case (state_q)
      SQ_IDLE: begin
        if (start_i) begin
          mode_d   = mode_i;
          primed_d = 1'b0;
          if (primed_q) begin
            state_d = launch_pick ? SQ_LAUNCH_SH : SQ_LAUNCH_FN;
          end else begin
            state_d = SQ_LOAD;
          end
        end
      end
      SQ_LOAD: begin
        if (last_i) begin
          state_d = launch_pick ? SQ_LAUNCH_SH : SQ_LAUNCH_FN;
        end
      end
      SQ_LAUNCH_SH: state_d = SQ_CAPTURE;
      SQ_LAUNCH_FN: state_d = SQ_CAPTURE;
      SQ_CAPTURE:   state_d = SQ_UNLOAD;
      SQ_UNLOAD: begin
        if (last_i) begin
          state_d  = SQ_IDLE;
          primed_d = 1'b1;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SQ_IDLE;
      mode_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      mode_q   <= mode_d;
      primed_q <= primed_d;
    end
  end

  always_comb begin
    ctrl_o    = SQ_CTRL_OFF;
    cnt_clr_o = 1'b0;
    cnt_inc_o = 1'b0;
    unload_o  = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        cnt_clr_o = 1'b1;
      end
      SQ_LOAD: begin
        ctrl_o    = '{tclk_en: 1'b1, se: 1'b1, fast: 1'b0, take: 1'b1};
        cnt_inc_o = 1'b1;
      end
      SQ_LAUNCH_SH: begin
        ctrl_o = '{tclk_en: 1'b1, se: 1'b1, fast: 1'b1, take: 1'b1};
      end
      SQ_LAUNCH_FN: begin
        ctrl_o = '{tclk_en: 1'b1, se: 1'b0, fast: 1'b1, take: 1'b0};
      end
      SQ_CAPTURE: begin
        ctrl_o = '{tclk_en: 1'b1, se: 1'b0, fast: 1'b1, take: 1'b0};
      end
      SQ_UNLOAD: begin
        ctrl_o    = '{tclk_en: 1'b1, se: 1'b1, fast: 1'b0, take: 1'b1};
        cnt_inc_o = 1'b1;
        unload_o  = 1'b1;
      end
      default: begin
        cnt_clr_o = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/dlytest_seq.sv
module dlytest_seq
  import dlytest_pkg::*;
#(
  parameter int CHAIN_LEN = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 mode_i,
  input  logic                 pat_bit_i,
  output logic                 pat_take_o,
  output logic                 scan_en_o,
  output logic                 scan_in_o,
  input  logic                 scan_out_i,
  output logic                 fast_clk_o,
  output logic                 tclk_en_o,
  output logic                 done_o,
  output logic [CHAIN_LEN-1:0] resp_o
);

  logic     rst_int_n;
  sq_ctrl_t ctrl;
  logic     cnt_clr, cnt_inc, cnt_last, unload;

  dlytest_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  dlytest_seq_fsm i_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_i   (start_i),
    .mode_i    (mode_i),
    .last_i    (cnt_last),
    .ctrl_o    (ctrl),
    .cnt_clr_o (cnt_clr),
    .cnt_inc_o (cnt_inc),
    .unload_o  (unload)
  );

  dlytest_bit_counter #(.CHAIN_LEN(CHAIN_LEN)) i_cnt (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .last_o (cnt_last)
  );

  dlytest_resp_unload #(.CHAIN_LEN(CHAIN_LEN)) i_unload (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .shift_i    (unload),
    .last_i     (cnt_last),
    .scan_out_i (scan_out_i),
    .resp_o     (resp_o),
    .done_o     (done_o)
  );

  assign pat_take_o = ctrl.take;
  assign scan_en_o  = ctrl.se;
  assign scan_in_o  = ctrl.take & pat_bit_i;
  assign fast_clk_o = ctrl.fast;
  assign tclk_en_o  = ctrl.tclk_en;

endmodule

// File: rtl/dlytest_seq_chk.sv
module dlytest_seq_chk #(
  parameter int CHAIN_LEN = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pat_take_o,
  input logic                 scan_en_o,
  input logic                 fast_clk_o,
  input logic                 tclk_en_o,
  input logic                 done_o,
  input logic [CHAIN_LEN-1:0] resp_o
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !tclk_en_o |-> (!scan_en_o && !fast_clk_o && !pat_take_o)); // R10

  AST_TAKE_SHIFTS: assert property (@(posedge clk) disable iff (!rst_n)
    pat_take_o |-> (scan_en_o && tclk_en_o)); // R2

  AST_LOW_SE_AT_SPEED: assert property (@(posedge clk) disable iff (!rst_n)
    (tclk_en_o && !scan_en_o) |-> fast_clk_o); // R4

  AST_SE_FALL_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scan_en_o) && tclk_en_o) |-> fast_clk_o); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7

  AST_DONE_AFTER_SLOW_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(scan_en_o && !fast_clk_o && tclk_en_o) && !tclk_en_o)); // R6

  AST_RESP_MOVES_ON_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(resp_o) |-> $past(scan_en_o && !fast_clk_o)); // R7

endmodule

bind dlytest_seq dlytest_seq_chk #(.CHAIN_LEN(CHAIN_LEN)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pat_take_o (pat_take_o),
  .scan_en_o  (scan_en_o),
  .fast_clk_o (fast_clk_o),
  .tclk_en_o  (tclk_en_o),
  .done_o     (done_o),
  .resp_o     (resp_o)
);

// File: tb/test_dlytest_seq.sv
module test_dlytest_seq;

  localparam int CL = 6;
  localparam logic [CL-1:0] MASK = '1;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic          mode_i;
  logic          pat_bit_i;
  logic          pat_take_o;
  logic          scan_en_o;
  logic          scan_in_o;
  logic          scan_out_i;
  logic          fast_clk_o;
  logic          tclk_en_o;
  logic          done_o;
  logic [CL-1:0] resp_o;

  dlytest_seq #(.CHAIN_LEN(CL)) i_dlytest_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .mode_i     (mode_i),
    .pat_bit_i  (pat_bit_i),
    .pat_take_o (pat_take_o),
    .scan_en_o  (scan_en_o),
    .scan_in_o  (scan_in_o),
    .scan_out_i (scan_out_i),
    .fast_clk_o (fast_clk_o),
    .tclk_en_o  (tclk_en_o),
    .done_o     (done_o),
    .resp_o     (resp_o)
  );

  // 200 MHz
  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // Pattern source stream and circuit-under-test behaviour (bench environment).
  function automatic logic pbit(int k);
    return (((k * 13 + 5) % 11) > 4) ? 1'b1 : 1'b0;
  endfunction

  function automatic logic [CL-1:0] fn(logic [CL-1:0] x);
    logic [CL-1:0] r;
    r = ((x << 1) | (x >> (CL - 1))) ^ (x >> 2) ^ (x & (x >> 1)) ^ 6'h2D;
    return r & MASK;
  endfunction

  int            pat_idx = 0;
  logic [CL-1:0] chain   = '0;

  always_comb pat_bit_i = pbit(pat_idx);
  assign scan_out_i = chain[CL-1];

  always @(posedge clk) begin
    if (pat_take_o) pat_idx <= pat_idx + 1;
    if (tclk_en_o) begin
      if (scan_en_o) chain <= {chain[CL-2:0], scan_in_o};
      else           chain <= fn(chain);
    end
  end

  // Reference: expected {tclk_en, se, fast, take, done} per cycle.
  logic [4:0]    exp_q[$];
  string         req_q[$];
  logic [CL-1:0] exp_resp  = '0;
  logic [CL-1:0] held_resp = '0;
  bit            started   = 0;
  bit            primed    = 0;
  int            ref_ptr   = 0;
  logic [CL-1:0] next_init = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && !finished) begin
      logic [4:0] act;
      logic [4:0] exp;
      string      req;
      bit         is_done;
      act = {tclk_en_o, scan_en_o, fast_clk_o, pat_take_o, done_o};
      if (exp_q.size() != 0) begin
        exp = exp_q.pop_front();
        req = req_q.pop_front();
      end else begin
        exp = 5'b00000;
        req = started ? "R10" : "R1";
      end
      is_done = exp[0];
      check(act == exp, req, "ctrl", 32'(act), 32'(exp));
      check(scan_in_o == (pat_take_o & pat_bit_i), "R11", "scan_in",
            32'(scan_in_o), 32'(pat_take_o & pat_bit_i));
      if (is_done) begin
        check(resp_o == exp_resp, "R7", "response", 32'(resp_o), 32'(exp_resp));
        held_resp = exp_resp;
      end else if (exp_q.size() == 0 && exp == 5'b00000) begin
        check(resp_o == held_resp, started ? "R7" : "R1", "resp hold",
              32'(resp_o), 32'(held_resp));
      end
    end
  end

  task automatic push(input logic [4:0] v, input string r);
    exp_q.push_back(v);
    req_q.push_back(r);
  endtask

  task automatic run_pat(input logic m, input bit poke);
    logic [CL-1:0] init, lv;
    @(negedge clk);
    if (!primed) begin
      init = '0;
      for (int k = 0; k < CL; k++) init[CL-1-k] = pbit(ref_ptr + k);
      ref_ptr += CL;
      for (int k = 0; k < CL; k++) push(5'b11010, "R2");
    end else begin
      init = next_init;
    end
    if (m) begin
      lv = {init[CL-2:0], pbit(ref_ptr)};
      ref_ptr++;
      push(5'b11110, primed ? "R8" : "R3");
    end else begin
      lv = fn(init);
      push(5'b10100, primed ? "R8" : "R4");
    end
    push(5'b10100, m ? "R3" : "R4");
    exp_resp = fn(lv);
    next_init = '0;
    for (int k = 0; k < CL; k++) next_init[CL-1-k] = pbit(ref_ptr + k);
    ref_ptr += CL;
    for (int k = 0; k < CL; k++) push(5'b11010, "R6");
    push(5'b00001, "R7");
    primed  = 1;
    started = 1;
    start_i = 1'b1;
    mode_i  = m;
    @(negedge clk);
    start_i = 1'b0;
    mode_i  = ~m;  // R9: mode changes after acceptance have no effect
    if (poke) begin
      repeat (3) @(negedge clk);
      start_i = 1'b1;  // R9: start while busy
      mode_i  = ~m;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n   = 1'b0;
    start_i = 1'b0;
    mode_i  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);     // R1 idle checks
    run_pat(1'b1, 1'b1);           // R2 R3 R9: first load, shifted launch, busy poke
    run_pat(1'b0, 1'b0);           // R8 R4: preloaded, response launch
    run_pat(1'b1, 1'b1);           // R8 R3: preloaded, shifted launch, poke in unload
    run_pat(1'b0, 1'b1);           // R4
    run_pat(1'b0, 1'b0);
    run_pat(1'b1, 1'b0);
    repeat (8) @(negedge clk);     // R10: idle, response held
    finish_run();
  end

endmodule